// File: doc/BRIEF.md
# Sample Rate Ratio Tracker

This block estimates how fast an input sample stream runs compared with an output sample stream. Both streams appear as single-cycle strobes in one system clock domain. The block counts the input strobes that fall inside a window of 64 output strobes and publishes the count as an 8-bit fixed-point ratio. The top two bits of the ratio are the integer part and the low six bits are the fraction, so a count of 64 reads as exactly 1.0.

A rate converter uses the ratio to set up its filters. While the measurement keeps moving, for example during a varispeed slew, the block holds an unlock flag high. Conversion carries on in a degraded tracking mode during that time. The flag drops once successive measurements agree. A separate sticky flag records any overflow that the converter's sample buffer reports, which happens when the input rate slews too fast for the buffer. After reset the ratio starts at unity, and the tracker is meant to follow ratios anywhere from 3:1 down to 1:3.

Top module: `rate_ratio_tracker`

## Requirements
- R1: `ratio` is in 2.6 fixed-point format. At the clock edge where the 64th output strobe of a window is sampled, it takes the number of input strobes sampled during that window, and the next window starts counting from zero.
- R2: While reset is asserted and after its release, `ratio` is 8'h40 (1.0), `rate_unlock` is 1 and `overflow` is 0.
- R3: An input strobe that comes in the same cycle as the closing output strobe counts toward the window that is closing.
- R4: The measurement saturates at 8'hFF when more than 255 input strobes fall inside one window.
- R5: `ratio` changes only at a window close.
- R6: `rate_unlock` goes to 0 at the window close that completes 4 consecutive measurements, each within 1 LSB of the value `ratio` held before it. It changes only at window closes.
- R7: A measurement that differs by more than 1 LSB from the previous `ratio` sets `rate_unlock` to 1 at that close and restarts the run of agreeing measurements.
- R8: `overflow` is 1 from the cycle after `fifo_overflow` is sampled high, and then stays 1.
- R9: `overflow_clear` sampled high clears `overflow` in the next cycle. If `fifo_overflow` is high in the same cycle, the set wins.
- R10: A 3:1 rate pair (an input strobe every 4 cycles, an output strobe every 12) reads 8'hC0. A 1:3 pair (input every 12, output every 4) reads 21 or 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | One-cycle pulse per input sample |
| out_strobe | input | 1 | One-cycle pulse per output sample |
| fifo_overflow | input | 1 | Overflow indication from the sample buffer |
| overflow_clear | input | 1 | Write-one-to-clear pulse for `overflow` |
| ratio | output | 8 | Measured input/output rate ratio, 2.6 fixed point |
| rate_unlock | output | 1 | High while the measured rate is not yet stable |
| overflow | output | 1 | Sticky buffer-overflow flag |

## Verification
The assertions assume that both strobes are synchronous single-cycle pulses and that `fifo_overflow` and `overflow_clear` are sampled only on clock edges. They make no assumption about the spacing between strobes. The stimulus generates every strobe from a per-cycle period counter, which changes only on the falling clock edge, so each pulse lasts exactly one cycle. Periods change only between windows or at arbitrary cycles that the reference model follows cycle by cycle. The overflow inputs are driven the same way, including one cycle in which set and clear are both high.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  localparam int unsigned RATIO_W = 8;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Add one event to a count, holding at all-ones.
  function automatic ratio_t sat_inc(ratio_t v, logic inc);
    if (inc && (v != '1)) return v + ratio_t'(1);
    return v;
  endfunction

  // True when two measurements are no more than tol LSB apart.
  function automatic logic within_tol(ratio_t a, ratio_t b, int unsigned tol);
    ratio_t diff;
    diff = (a > b) ? (a - b) : (b - a);
    return (32'(diff) <= tol);
  endfunction

endpackage

// File: rtl/rrt_window.sv
module rrt_window
  import rrt_pkg::*;
#(
  parameter int unsigned FRAC_W = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_strobe,
  input  logic   out_strobe,
  output logic   win_close,
  output ratio_t meas_value
);
  localparam int unsigned WIN = 1 << FRAC_W;

  logic [FRAC_W-1:0] out_cnt;
  ratio_t            in_cnt;

  assign win_close  = out_strobe && (out_cnt == FRAC_W'(WIN - 1));
  assign meas_value = sat_inc(in_cnt, in_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      in_cnt  <= '0;
    end else begin
      if (out_strobe) out_cnt <= out_cnt + 1'b1;
      if (win_close) in_cnt <= '0;
      else           in_cnt <= meas_value;
    end
  end
endmodule

// File: rtl/rrt_lock.sv
module rrt_lock
  import rrt_pkg::*;
#(
  parameter int unsigned STABLE_N = 4,
  parameter int unsigned TOL      = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   meas_valid,
  input  ratio_t meas_value,
  input  ratio_t prev_value,
  output logic   meas_close,
  output logic   unlock
);
  localparam int unsigned RUN_W = $clog2(STABLE_N + 1);

  logic [RUN_W-1:0] run;

  generate
    if (TOL == 0) begin : g_exact
      assign meas_close = (meas_value == prev_value);
    end else begin : g_tol
      assign meas_close = within_tol(meas_value, prev_value, TOL);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (meas_valid) begin
      if (!meas_close)                    run <= '0;
      else if (run != RUN_W'(STABLE_N))   run <= run + 1'b1;
    end
  end

  assign unlock = (run != RUN_W'(STABLE_N));
endmodule

// File: rtl/rrt_sticky.sv
module rrt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_in,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_in) flag <= 1'b1;
    else if (clr_in) flag <= 1'b0;
  end
endmodule

// File: rtl/rate_ratio_tracker.sv
module rate_ratio_tracker
  import rrt_pkg::*;
#(
  parameter int unsigned FRAC_W   = 6,
  parameter int unsigned STABLE_N = 4,
  parameter int unsigned TOL      = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_strobe,
  input  logic               out_strobe,
  input  logic               fifo_overflow,
  input  logic               overflow_clear,
  output logic [RATIO_W-1:0] ratio,
  output logic               rate_unlock,
  output logic               overflow
);
  localparam ratio_t UNITY = ratio_t'(1 << FRAC_W);

  // Internal events, named for the checker.
  logic   meas_valid;
  ratio_t meas_value;
  logic   meas_close;
  ratio_t ratio_q;

  rrt_window #(.FRAC_W(FRAC_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_strobe  (in_strobe),
    .out_strobe (out_strobe),
    .win_close  (meas_valid),
    .meas_value (meas_value)
  );

  rrt_lock #(.STABLE_N(STABLE_N), .TOL(TOL)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_value (meas_value),
    .prev_value (ratio_q),
    .meas_close (meas_close),
    .unlock     (rate_unlock)
  );

  rrt_sticky u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (fifo_overflow),
    .clr_in (overflow_clear),
    .flag   (overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ratio_q <= UNITY;
    else if (meas_valid) ratio_q <= meas_value;
  end

  assign ratio = ratio_q;
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_overflow,
  input logic       overflow_clear,
  input logic       meas_valid,
  input logic       meas_close,
  input logic [7:0] ratio,
  input logic       rate_unlock,
  input logic       overflow
);
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(ratio)); // R5

  AST_UNLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(rate_unlock)); // R6

  AST_UNLOCK_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_close) |=> rate_unlock); // R7

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> overflow); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !overflow_clear) |=> overflow); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_clear && !fifo_overflow) |=> !overflow); // R9
endmodule

bind rate_ratio_tracker rrt_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fifo_overflow  (fifo_overflow),
  .overflow_clear (overflow_clear),
  .meas_valid     (meas_valid),
  .meas_close     (meas_close),
  .ratio          (ratio),
  .rate_unlock    (rate_unlock),
  .overflow       (overflow)
);

// File: tb/rate_ratio_tracker_test.sv
module rate_ratio_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_strobe = 1'b0;
  logic       out_strobe = 1'b0;
  logic       fifo_overflow = 1'b0;
  logic       overflow_clear = 1'b0;
  logic [7:0] ratio;
  logic       rate_unlock;
  logic       overflow;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // stimulus periods (0 = no strobes) and phase counters
  int pi = 0, po = 0, ci = 0, co = 0;

  // reference model state
  int m_in = 0, m_out = 0, m_ratio = 64, m_run = 0, m_ovf = 0;

  always #4 clk = ~clk;

  rate_ratio_tracker uut (
    .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .out_strobe(out_strobe),
    .fifo_overflow(fifo_overflow), .overflow_clear(overflow_clear),
    .ratio(ratio), .rate_unlock(rate_unlock), .overflow(overflow)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_out = 0; m_ratio = 64; m_run = 0; m_ovf = 0;
    end else begin
      if (in_strobe && m_in < 255) m_in++;
      if (out_strobe) begin
        m_out++;
        if (m_out == 64) begin
          int d;
          d = m_in - m_ratio;
          if (d < 0) d = -d;
          if (d <= 1) begin
            if (m_run < 4) m_run++;
          end else m_run = 0;
          m_ratio = m_in;
          m_in = 0;
          m_out = 0;
        end
      end
      if (fifo_overflow) m_ovf = 1;
      else if (overflow_clear) m_ovf = 0;
    end
  end

  // compare on every cycle, then drive the next strobes
  always @(negedge clk) begin
    if (rst_n) begin
      check(ratio == 8'(m_ratio), "R1/R5 ratio", ratio, m_ratio);
      check(rate_unlock == (m_run < 4), "R6 unlock", rate_unlock, m_run < 4);
      check(overflow == m_ovf[0], "R8 overflow", overflow, m_ovf);
    end
    in_strobe  = (pi > 0) && (ci == 0);
    out_strobe = (po > 0) && (co == 0);
    if (pi > 0) ci = (ci + 1 >= pi) ? 0 : ci + 1;
    if (po > 0) co = (co + 1 >= po) ? 0 : co + 1;
  end

  task automatic windows(int n);
    repeat (n * 64 * po + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ratio == 8'h40, "R2 reset ratio", ratio, 64);
    check(rate_unlock == 1'b1, "R2 reset unlock", rate_unlock, 1);
    check(overflow == 1'b0, "R2 reset overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ratio == 8'h40 && rate_unlock && !overflow, "R2 after release", ratio, 64);

    // equal aligned rates: closing out strobe coincides with an in strobe
    ci = 0; co = 0; pi = 8; po = 8;
    windows(6);
    check(ratio == 8'd64, "R3 coincident strobe counted", ratio, 64);
    check(rate_unlock == 1'b0, "R6 locked at unity", rate_unlock, 0);

    // 3:1
    pi = 4; po = 12;
    windows(2);
    check(rate_unlock == 1'b1, "R7 unlock after jump", rate_unlock, 1);
    windows(5);
    check(ratio == 8'hC0, "R10 ratio 3:1", ratio, 192);
    check(rate_unlock == 1'b0, "R6 locked at 3:1", rate_unlock, 0);

    // 1:3
    pi = 12; po = 4;
    windows(7);
    check(ratio == 8'd21 || ratio == 8'd22, "R10 ratio 1:3", ratio, 21);
    check(rate_unlock == 1'b0, "R6 locked at 1:3", rate_unlock, 0);

    // saturation
    pi = 1; po = 8;
    windows(3);
    check(ratio == 8'hFF, "R4 saturation", ratio, 255);

    // varispeed: input period moves every window
    for (int k = 0; k < 6; k++) begin
      pi = (k % 2 == 0) ? 6 : 8;
      windows(1);
    end
    check(rate_unlock == 1'b1, "R7 unlock while slewing", rate_unlock, 1);

    // overflow flag
    fifo_overflow = 1'b1;
    @(negedge clk);
    fifo_overflow = 1'b0;
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    repeat (5) @(negedge clk);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    overflow_clear = 1'b1;
    @(negedge clk);
    overflow_clear = 1'b0;
    check(overflow == 1'b0, "R9 overflow cleared", overflow, 0);
    fifo_overflow = 1'b1;
    overflow_clear = 1'b1;
    @(negedge clk);
    fifo_overflow = 1'b0;
    overflow_clear = 1'b0;
    check(overflow == 1'b1, "R9 set wins over clear", overflow, 1);
    repeat (4) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule